// File: doc/BRIEF.md
# Four-Phase Bridge Dead-Time Interlock

This block is a synchronous gate-enable controller for four half-bridge phases that operate independently of one another. Each phase has a high-side command and a low-side command, and it drives one high-side and one low-side gate enable. The eight enables can serve a four-phase bridge or a pair of full bridges. The high-side command is active-low. In the normal interlocked mode, the low-side command takes priority over the high-side command.

A dead-time count, given in clock cycles, delays the turn-on of every enable. Turn-off has no added delay. A global enable clears all eight outputs. A bypass mode removes both the interlock and the delay, so both switches of a phase can be driven together. All commands are registered before they are decoded. As a result, each output changes two clock edges after its input changes, plus the dead-time count on a turn-on.

Top module: `bridge_interlock`

## Requirements
- R1: While rst_n is low, all high-side and low-side gate enables are 0, whatever the commands are.
- R2: With enable=1, bypass=0 and the low-side command of a phase at 0, the high-side enable of that phase is the inverse of its active-low high-side command, and its low-side enable is 0.
- R3: With enable=1 and bypass=0, a low-side command of 1 turns that phase's low-side enable on and its high-side enable off, whatever the high-side command is.
- R4: With the high-side command held at 0, toggling the low-side command alone switches the phase between low-on and high-on, as a complementary pair.
- R5: Two clock edges after enable is sampled low, all eight enables are 0, overriding every other input.
- R6: When an enable's resolved request goes from off to on with dead-time count D, the enable is 0 for D+1 edges after the command is applied and is 1 after edge D+2.
- R7: An enable whose request goes from on to off is 0 two edges after the command change, whatever the value of D.
- R8: A request that lasts fewer cycles than D never asserts its enable.
- R9: When enable returns high, each requested output waits the full D+2 edges before it asserts.
- R10: With bypass=1 and enable=1, each high-side enable is the inverse of its high-side command and each low-side enable equals its low-side command, two edges after the command, with no dead time. Both enables of a phase may be 1 together.
- R11: A change in the commands of one phase does not affect the enables of any other phase.
- R12: If the dead-time count is lowered while a turn-on is pending, the enable asserts on the first edge at which the cycles already counted reach the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_n | input | NUM_PHASES | Active-low high-side commands, bit i = phase i |
| lo_cmd | input | NUM_PHASES | Active-high low-side commands |
| enable | input | 1 | Global enable; 0 forces all outputs off |
| bypass | input | 1 | 1 removes interlock and dead time |
| dt_cycles | input | DT_W | Turn-on delay in clock cycles |
| hs_gate | output | NUM_PHASES | High-side gate enables |
| ls_gate | output | NUM_PHASES | Low-side gate enables |

## Verification
The bench builds the block with NUM_PHASES=4 and DT_W=4. With this narrow count width the largest dead time, 15 cycles, can be tested directly alongside small values and zero. Dead times of 0, 2, 3, 4, 5, 7, 10 and 15 cover the turn-on boundary at D+1 and D+2 edges, a request cancelled before its count expires, a count lowered mid-flight, and re-arming after enable is restored. Four phases are enough to show that changing one phase leaves the others untouched.

// File: rtl/bridge_interlock_pkg.sv
package bridge_interlock_pkg;

    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_LOCKED = 2'd1,
        DRV_DIRECT = 2'd2
    } drive_mode_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } phase_req_t;

    function automatic drive_mode_e pick_mode(input logic en, input logic byp);
        if (!en)
            return DRV_OFF;
        else if (byp)
            return DRV_DIRECT;
        else
            return DRV_LOCKED;
    endfunction

    function automatic phase_req_t resolve_phase(input drive_mode_e mode,
                                                 input logic hi_n,
                                                 input logic lo);
        phase_req_t r;
        r.hs = 1'b0;
        r.ls = 1'b0;
        case (mode)
            DRV_DIRECT: begin
                r.hs = ~hi_n;
                r.ls = lo;
            end
            DRV_LOCKED: begin
                if (lo) begin
                    r.ls = 1'b1;
                end else begin
                    r.hs = ~hi_n;
                end
            end
            default: begin
                r.hs = 1'b0;
                r.ls = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bi_cmd_reg.sv
module bi_cmd_reg #(
    parameter int NUM_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] hi_cmd_n,
    input  logic [NUM_PHASES-1:0] lo_cmd,
    input  logic                  enable,
    input  logic                  bypass,
    output logic [NUM_PHASES-1:0] hi_n_q,
    output logic [NUM_PHASES-1:0] lo_q,
    output logic                  en_q,
    output logic                  byp_q
);

    typedef struct packed {
        logic [NUM_PHASES-1:0] hi_n;
        logic [NUM_PHASES-1:0] lo;
        logic                  en;
        logic                  byp;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d      = cmd_q;
        cmd_d.hi_n = hi_cmd_n;
        cmd_d.lo   = lo_cmd;
        cmd_d.en   = enable;
        cmd_d.byp  = bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q.hi_n <= '1;
            cmd_q.lo   <= '0;
            cmd_q.en   <= 1'b0;
            cmd_q.byp  <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign hi_n_q = cmd_q.hi_n;
    assign lo_q   = cmd_q.lo;
    assign en_q   = cmd_q.en;
    assign byp_q  = cmd_q.byp;

endmodule

// File: rtl/bi_resolve.sv
module bi_resolve
    import bridge_interlock_pkg::*;
#(
    parameter int NUM_PHASES = 4
) (
    input  logic [NUM_PHASES-1:0] hi_n_q,
    input  logic [NUM_PHASES-1:0] lo_q,
    input  logic                  en_q,
    input  logic                  byp_q,
    output logic [NUM_PHASES-1:0] hs_req,
    output logic [NUM_PHASES-1:0] ls_req,
    output logic                  direct
);

    drive_mode_e mode;

    always_comb begin
        mode   = pick_mode(en_q, byp_q);
        direct = (mode == DRV_DIRECT);
    end

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        phase_req_t req;
        always_comb begin
            req       = resolve_phase(mode, hi_n_q[p], lo_q[p]);
            hs_req[p] = req.hs;
            ls_req[p] = req.ls;
        end
    end

endmodule

// File: rtl/bi_turnon_delay.sv
module bi_turnon_delay #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            direct,
    input  logic [DT_W-1:0] dt_cycles,
    output logic            gate
);

    typedef struct packed {
        logic [DT_W-1:0] cnt;
        logic            on;
    } dly_t;

    dly_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (direct) begin
            st_d.on  = req;
            st_d.cnt = '0;
        end else if (!req) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.on) begin
            if (st_q.cnt >= dt_cycles) begin
                st_d.on = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.on  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate = st_q.on;

endmodule

// File: rtl/bridge_interlock.sv
module bridge_interlock #(
    parameter int NUM_PHASES = 4,
    parameter int DT_W       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] hi_cmd_n,
    input  logic [NUM_PHASES-1:0] lo_cmd,
    input  logic                  enable,
    input  logic                  bypass,
    input  logic [DT_W-1:0]       dt_cycles,
    output logic [NUM_PHASES-1:0] hs_gate,
    output logic [NUM_PHASES-1:0] ls_gate
);

    localparam int NUM_GATES = 2 * NUM_PHASES;

    logic [NUM_PHASES-1:0] hi_n_q;
    logic [NUM_PHASES-1:0] lo_q;
    logic                  en_q;
    logic                  byp_q;
    logic [NUM_PHASES-1:0] hs_req;
    logic [NUM_PHASES-1:0] ls_req;
    logic                  direct;
    logic [NUM_GATES-1:0]  req_all;
    logic [NUM_GATES-1:0]  gate_all;

    bi_cmd_reg #(.NUM_PHASES(NUM_PHASES)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd_n (hi_cmd_n),
        .lo_cmd   (lo_cmd),
        .enable   (enable),
        .bypass   (bypass),
        .hi_n_q   (hi_n_q),
        .lo_q     (lo_q),
        .en_q     (en_q),
        .byp_q    (byp_q)
    );

    bi_resolve #(.NUM_PHASES(NUM_PHASES)) u_res (
        .hi_n_q (hi_n_q),
        .lo_q   (lo_q),
        .en_q   (en_q),
        .byp_q  (byp_q),
        .hs_req (hs_req),
        .ls_req (ls_req),
        .direct (direct)
    );

    assign req_all = {ls_req, hs_req};

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        bi_turnon_delay #(.DT_W(DT_W)) u_dly (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_all[g]),
            .direct    (direct),
            .dt_cycles (dt_cycles),
            .gate      (gate_all[g])
        );
    end

    assign hs_gate = gate_all[NUM_PHASES-1:0];
    assign ls_gate = gate_all[NUM_GATES-1:NUM_PHASES];

endmodule

// File: rtl/bridge_interlock_chk.sv
module bridge_interlock_chk #(
    parameter int NUM_PHASES = 4,
    parameter int DT_W       = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PHASES-1:0] hi_cmd_n,
    input logic [NUM_PHASES-1:0] lo_cmd,
    input logic                  enable,
    input logic                  bypass,
    input logic [DT_W-1:0]       dt_cycles,
    input logic [NUM_PHASES-1:0] hs_gate,
    input logic [NUM_PHASES-1:0] ls_gate
);

    logic [NUM_PHASES-1:0] hi_p1, hi_p2, lo_p1, lo_p2, lo_p3;
    logic en_p1, en_p2, byp_p1, byp_p2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_p1 <= '1; hi_p2 <= '1;
            lo_p1 <= '0; lo_p2 <= '0; lo_p3 <= '0;
            en_p1 <= 1'b0; en_p2 <= 1'b0;
            byp_p1 <= 1'b0; byp_p2 <= 1'b0;
        end else begin
            hi_p1 <= hi_cmd_n; hi_p2 <= hi_p1;
            lo_p1 <= lo_cmd;   lo_p2 <= lo_p1; lo_p3 <= lo_p2;
            en_p1 <= enable;   en_p2 <= en_p1;
            byp_p1 <= bypass;  byp_p2 <= byp_p1;
        end
    end

    // R1: outputs off while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_off_R1: assert (hs_gate == '0 && ls_gate == '0);
        end
    end

    // R5: disabled two edges ago means all off
    assert_disable_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_p2 |-> (hs_gate == '0 && ls_gate == '0));

    // R10: bypass follows commands directly
    assert_bypass_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_p2 && byp_p2) |-> (hs_gate == ~hi_p2 && ls_gate == lo_p2));

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
        // R3: low-side command has priority when interlocked
        assert_lo_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_p2 && !byp_p2 && lo_p2[p]) |-> !hs_gate[p]);

        // R7: low-side turn-off carries no delay
        assert_ls_off_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!byp_p2 && !lo_p2[p]) |-> !ls_gate[p]);

        // R6: a delayed low-side turn-on was requested on the previous cycle too
        assert_ls_rise_delayed_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ls_gate[p]) && !byp_p2 && $past(dt_cycles) != '0) |-> lo_p3[p]);
    end

endmodule

bind bridge_interlock bridge_interlock_chk #(
    .NUM_PHASES(NUM_PHASES),
    .DT_W(DT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_cmd_n  (hi_cmd_n),
    .lo_cmd    (lo_cmd),
    .enable    (enable),
    .bypass    (bypass),
    .dt_cycles (dt_cycles),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
);

// File: tb/bridge_interlock_tb_top.sv
module bridge_interlock_tb_top;

    localparam int NP = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hi_cmd_n = '1;
    logic [NP-1:0] lo_cmd = '0;
    logic          enable = 1'b0;
    logic          bypass = 1'b0;
    logic [DW-1:0] dt_cycles = '0;
    logic [NP-1:0] hs_gate, ls_gate;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bridge_interlock #(.NUM_PHASES(NP), .DT_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd(lo_cmd),
        .enable(enable), .bypass(bypass), .dt_cycles(dt_cycles),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic [NP-1:0] h, input logic [NP-1:0] l,
                         input logic en, input logic byp, input logic [DW-1:0] dt);
        hi_cmd_n = h; lo_cmd = l; enable = en; bypass = byp; dt_cycles = dt;
    endtask

    task automatic t_reset;
        drive(4'b0000, 4'b1010, 1'b1, 1'b1, 4'd0);
        tick(3);
        check("R1 hs", hs_gate, 4'b0000);
        check("R1 ls", ls_gate, 4'b0000);
        drive(4'b1111, 4'b0000, 1'b0, 1'b0, 4'd0);
        rst_n = 1'b1;
        tick(3);
        check("R1 after release hs", hs_gate, 4'b0000);
    endtask

    task automatic t_hs_decode;
        drive(4'b0101, 4'b0000, 1'b1, 1'b0, 4'd0);
        tick(2);
        check("R2 hs", hs_gate, 4'b1010);
        check("R2 ls", ls_gate, 4'b0000);
        drive(4'b1100, 4'b0000, 1'b1, 1'b0, 4'd0);
        tick(2);
        check("R2 hs second", hs_gate, 4'b0011);
    endtask

    task automatic t_priority;
        drive(4'b0000, 4'b0011, 1'b1, 1'b0, 4'd0);
        tick(2);
        check("R3 ls", ls_gate, 4'b0011);
        check("R3 hs", hs_gate, 4'b1100);
    endtask

    task automatic t_complement;
        drive(4'b0000, 4'b0000, 1'b1, 1'b0, 4'd3);
        tick(8);
        check("R4 start hs", hs_gate, 4'b1111);
        drive(4'b0000, 4'b1111, 1'b1, 1'b0, 4'd3);
        tick(2);
        check("R7 hs off", hs_gate, 4'b0000);
        check("R6 ls gap", ls_gate, 4'b0000);
        tick(2);
        check("R6 ls still off at D+1", ls_gate, 4'b0000);
        tick(1);
        check("R4 ls on", ls_gate, 4'b1111);
        drive(4'b0000, 4'b0000, 1'b1, 1'b0, 4'd3);
        tick(2);
        check("R7 ls off", ls_gate, 4'b0000);
        tick(2);
        check("R6 hs still off", hs_gate, 4'b0000);
        tick(1);
        check("R4 hs back", hs_gate, 4'b1111);
    endtask

    task automatic t_cancel;
        drive(4'b0000, 4'b1111, 1'b1, 1'b0, 4'd5);
        tick(10);
        drive(4'b0000, 4'b0000, 1'b1, 1'b0, 4'd5);
        tick(2);
        check("R8 ls dropped", ls_gate, 4'b0000);
        drive(4'b0000, 4'b1111, 1'b1, 1'b0, 4'd5);
        for (int i = 0; i < 6; i++) begin
            tick(1);
            check("R8 hs never on", hs_gate, 4'b0000);
        end
        tick(1);
        check("R8 ls restarted", ls_gate, 4'b1111);
    endtask

    task automatic t_enable;
        drive(4'b0000, 4'b1111, 1'b1, 1'b0, 4'd4);
        tick(8);
        drive(4'b0000, 4'b1111, 1'b0, 1'b0, 4'd4);
        tick(2);
        check("R5 ls off", ls_gate, 4'b0000);
        check("R5 hs off", hs_gate, 4'b0000);
        tick(4);
        drive(4'b0000, 4'b1111, 1'b1, 1'b0, 4'd4);
        tick(5);
        check("R9 waits", ls_gate, 4'b0000);
        tick(1);
        check("R9 asserts", ls_gate, 4'b1111);
    endtask

    task automatic t_bypass;
        drive(4'b0000, 4'b1111, 1'b1, 1'b1, 4'd7);
        tick(2);
        check("R10 hs", hs_gate, 4'b1111);
        check("R10 ls", ls_gate, 4'b1111);
        drive(4'b0110, 4'b0101, 1'b1, 1'b1, 4'd7);
        tick(2);
        check("R10 hs pattern", hs_gate, 4'b1001);
        check("R10 ls pattern", ls_gate, 4'b0101);
        drive(4'b1111, 4'b0000, 1'b1, 1'b0, 4'd0);
        tick(3);
    endtask

    task automatic t_indep;
        drive(4'b0000, 4'b0000, 1'b1, 1'b0, 4'd2);
        tick(6);
        drive(4'b0000, 4'b0100, 1'b1, 1'b0, 4'd2);
        for (int i = 0; i < 5; i++) begin
            tick(1);
            if (i >= 1) check("R11 other phases hs", hs_gate, 4'b1011);
        end
        check("R11 phase 2 ls", ls_gate, 4'b0100);
    endtask

    task automatic t_shrink;
        drive(4'b1111, 4'b0000, 1'b1, 1'b0, 4'd10);
        tick(4);
        drive(4'b1111, 4'b1111, 1'b1, 1'b0, 4'd10);
        tick(4);
        check("R12 pending", ls_gate, 4'b0000);
        dt_cycles = 4'd2;
        tick(1);
        check("R12 asserts at new count", ls_gate, 4'b1111);
    endtask

    task automatic t_maxdt;
        drive(4'b1111, 4'b0000, 1'b1, 1'b0, 4'd15);
        tick(4);
        drive(4'b1111, 4'b1111, 1'b1, 1'b0, 4'd15);
        tick(16);
        check("R6 max D still off", ls_gate, 4'b0000);
        tick(1);
        check("R6 max D on", ls_gate, 4'b1111);
    endtask

    initial begin
        t_reset();
        t_hs_decode();
        t_priority();
        t_complement();
        t_cancel();
        t_enable();
        t_bypass();
        t_indep();
        t_shrink();
        t_maxdt();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule